// File: doc/BRIEF.md
# Multiply-Accumulate with Wrap Pulse

This block multiplies two operands and adds the product into a running accumulator on every clock cycle in which its enable is high. A mode input chooses between unsigned and two's-complement arithmetic. Operands narrower than the native multiplier width (9, 18 or 36 bits) are widened first: zero-filled in unsigned mode and sign-extended in signed mode. The accumulator is twice the native width plus a small number of guard bits. The block has a single register stage, so a result appears one cycle after the inputs that caused it.

Whenever an addition wraps the accumulator, a flag goes high for exactly one cycle. In unsigned mode a wrap means a carry out of the top bit. In signed mode it means the accumulator and the product share a sign but the result has the opposite sign. Logic outside the block can count these pulses to extend the accumulator. In signed mode the accumulator's top bit, seen in the same cycle as the pulse, gives the direction of the wrap. A synchronous clear empties the accumulator.

Top module: `mac_ovf_acc`

## Requirements
- R1: The native operand width OP_W accepts only 9, 18 or 36. The accumulator width ACC_W equals 2*OP_W + GUARD_W (20 bits with the defaults OP_W=9, GUARD_W=2).
- R2: With `sgn_mode`=0 (unsigned), both operands are zero-filled to OP_W and their unsigned product is accumulated. For example, a=6'h3F and b=9'h1FF added to zero give 32193.
- R3: With `sgn_mode`=1 (signed), both operands are sign-extended from their own top bit to OP_W and their two's-complement product is accumulated. For example, a=6'h3F and b=9'h1FF added to zero give 1.
- R4: When `en`=1 and `clr`=0, `acc_out` one cycle later equals its previous value plus the product, modulo 2^ACC_W.
- R5: When `en`=0 and `clr`=0, `acc_out` keeps its value and `ovf_pulse` is 0 in the following cycle.
- R6: When `clr`=1, the next cycle shows `acc_out`=0 and `ovf_pulse`=0. This holds whatever `en` is, and even if the addition would have wrapped.
- R7: In unsigned mode, `ovf_pulse` is 1 in the cycle after an accumulation exactly when the new `acc_out` is smaller than the old one.
- R8: In signed mode, `ovf_pulse` is 1 in the cycle after an accumulation exactly when the old accumulator and the product have the same sign bit and the new accumulator has the other sign bit.
- R9: Each wrap produces a one-cycle pulse. A cycle that does not wrap shows `ovf_pulse`=0, even if the cycle before it pulsed.
- R10: With `rst`=1 at a clock edge, the next cycle shows `acc_out`=0 and `ovf_pulse`=0.
- R11: Counting pulses recovers the true sum. In unsigned mode, pulses * 2^ACC_W + `acc_out` equals the exact sum. In signed mode, each pulse counts +1 if `acc_out`'s top bit is 1 in that cycle and -1 otherwise. The net count * 2^ACC_W + signed `acc_out` equals the exact sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Accumulate the product this cycle |
| clr | input | 1 | Synchronous clear of the accumulator, overrides `en` |
| sgn_mode | input | 1 | 0 = unsigned, 1 = two's complement |
| a_in | input | A_W (6) | First operand |
| b_in | input | B_W (9) | Second operand |
| acc_out | output | ACC_W (20) | Accumulator value |
| ovf_pulse | output | 1 | One-cycle wrap indication |

## Verification
Two functions can fall in the same cycle: a clear, and an accumulation whose addition would wrap. The bench provokes this by filling the unsigned accumulator with maximal products until the next one is bound to carry out. It then raises `clr` together with `en` on that cycle. The result is judged correct only if the accumulator reads zero and no pulse appears. A second collision checked is a wrap immediately followed by a hold cycle: the pulse must drop after one cycle while the wrapped value stays.

// File: rtl/mac_ovf_pkg.sv
package mac_ovf_pkg;

  typedef enum logic {
    MODE_UNSIGNED = 1'b0,
    MODE_SIGNED   = 1'b1
  } mac_mode_e;

  // Native multiplier widths the block accepts.
  function automatic bit op_width_ok(input int w);
    return (w == 9) || (w == 18) || (w == 36);
  endfunction

endpackage

// File: rtl/mac_operand_widen.sv
module mac_operand_widen #(
  parameter int IN_W = 6,
  parameter int OP_W = 9
) (
  input  logic            sgn,
  input  logic [IN_W-1:0] din,
  output logic [OP_W-1:0] dout
);

  generate
    if (IN_W > OP_W) begin : g_too_wide
      $error("operand wider than native width");
    end else if (IN_W == OP_W) begin : g_native
      assign dout = din;
    end else begin : g_extend
      localparam int PAD_W = OP_W - IN_W;

      // Fill bit is the operand's top bit in signed mode, zero otherwise.
      function automatic logic [OP_W-1:0] widen(input logic [IN_W-1:0] d,
                                                input logic s);
        logic fill;
        fill = s & d[IN_W-1];
        return {{PAD_W{fill}}, d};
      endfunction

      assign dout = widen(din, sgn);
    end
  endgenerate

endmodule

// File: rtl/mac_product.sv
module mac_product #(
  parameter int OP_W  = 9,
  parameter int ACC_W = 20
) (
  input  logic             sgn,
  input  logic [OP_W-1:0]  a_op,
  input  logic [OP_W-1:0]  b_op,
  output logic [ACC_W-1:0] prod_ext
);

  localparam int EXT_W = ACC_W - OP_W;

  // Both operands are carried to the accumulator width before multiplying.
  // ACC_W >= 2*OP_W, so the truncated product is the exact product in
  // two's complement (signed) or binary (unsigned).
  function automatic logic [ACC_W-1:0] mul_ext(input logic [OP_W-1:0] x,
                                               input logic [OP_W-1:0] y,
                                               input logic s);
    logic [ACC_W-1:0] xe;
    logic [ACC_W-1:0] ye;
    xe = {{EXT_W{s & x[OP_W-1]}}, x};
    ye = {{EXT_W{s & y[OP_W-1]}}, y};
    return xe * ye;
  endfunction

  assign prod_ext = mul_ext(a_op, b_op, sgn);

endmodule

// File: rtl/mac_wrap_detect.sv
module mac_wrap_detect #(
  parameter int ACC_W = 20
) (
  input  logic             sgn,
  input  logic [ACC_W-1:0] acc_cur,
  input  logic [ACC_W-1:0] addend,
  output logic [ACC_W-1:0] sum_nxt,
  output logic             wrap_evt
);

  localparam int TOP = ACC_W - 1;

  function automatic logic [ACC_W:0] add_carry(input logic [ACC_W-1:0] x,
                                               input logic [ACC_W-1:0] y);
    return {1'b0, x} + {1'b0, y};
  endfunction

  // Signed wrap: equal input signs, differing result sign.
  function automatic logic signed_wrap(input logic xs, input logic ys,
                                       input logic rs);
    return (xs == ys) && (rs != xs);
  endfunction

  logic [ACC_W:0] full_sum;
  logic           carry_out;
  logic           sgn_wrap;

  assign full_sum  = add_carry(acc_cur, addend);
  assign sum_nxt   = full_sum[TOP:0];
  assign carry_out = full_sum[ACC_W];
  assign sgn_wrap  = signed_wrap(acc_cur[TOP], addend[TOP], full_sum[TOP]);
  assign wrap_evt  = sgn ? sgn_wrap : carry_out;

endmodule

// File: rtl/mac_ovf_acc.sv
module mac_ovf_acc
  import mac_ovf_pkg::*;
#(
  parameter int OP_W    = 9,
  parameter int A_W     = 6,
  parameter int B_W     = 9,
  parameter int GUARD_W = 2,
  localparam int ACC_W  = 2 * OP_W + GUARD_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             clr,
  input  logic             sgn_mode,
  input  logic [A_W-1:0]   a_in,
  input  logic [B_W-1:0]   b_in,
  output logic [ACC_W-1:0] acc_out,
  output logic             ovf_pulse
);

  generate
    if (!op_width_ok(OP_W)) begin : g_bad_op_w
      $error("OP_W must be 9, 18 or 36");
    end
  endgenerate

  mac_mode_e        mode;
  logic [OP_W-1:0]  a_op;
  logic [OP_W-1:0]  b_op;
  logic [ACC_W-1:0] prod_ext;
  logic [ACC_W-1:0] sum_nxt;
  logic             wrap_evt;
  logic [ACC_W-1:0] acc_q;
  logic             ovf_q;

  assign mode = mac_mode_e'(sgn_mode);

  mac_operand_widen #(.IN_W(A_W), .OP_W(OP_W)) u_widen_a (
    .sgn  (mode == MODE_SIGNED),
    .din  (a_in),
    .dout (a_op)
  );

  mac_operand_widen #(.IN_W(B_W), .OP_W(OP_W)) u_widen_b (
    .sgn  (mode == MODE_SIGNED),
    .din  (b_in),
    .dout (b_op)
  );

  mac_product #(.OP_W(OP_W), .ACC_W(ACC_W)) u_prod (
    .sgn      (mode == MODE_SIGNED),
    .a_op     (a_op),
    .b_op     (b_op),
    .prod_ext (prod_ext)
  );

  mac_wrap_detect #(.ACC_W(ACC_W)) u_wrap (
    .sgn      (mode == MODE_SIGNED),
    .acc_cur  (acc_q),
    .addend   (prod_ext),
    .sum_nxt  (sum_nxt),
    .wrap_evt (wrap_evt)
  );

  // Single register stage: accumulator and pulse update together.
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      acc_q <= '0;
      ovf_q <= 1'b0;
    end else if (en) begin
      acc_q <= sum_nxt;
      ovf_q <= wrap_evt;
    end else begin
      ovf_q <= 1'b0;
    end
  end

  assign acc_out   = acc_q;
  assign ovf_pulse = ovf_q;

endmodule

// File: rtl/mac_ovf_acc_chk.sv
module mac_ovf_acc_chk #(
  parameter int ACC_W = 20
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic             clr,
  input logic             sgn_mode,
  input logic [ACC_W-1:0] acc_out,
  input logic             ovf_pulse,
  input logic [ACC_W-1:0] prod_ext
);

  localparam int TOP = ACC_W - 1;

  assert_reset_R10: assert property (@(posedge clk)
    rst |=> (acc_out == '0) && !ovf_pulse);

  assert_accumulate_R4: assert property (@(posedge clk) disable iff (rst)
    (en && !clr) |=> acc_out == ACC_W'($past(acc_out) + $past(prod_ext)));

  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!en && !clr) |=> $stable(acc_out) && !ovf_pulse);

  assert_clear_R6: assert property (@(posedge clk) disable iff (rst)
    clr |=> (acc_out == '0) && !ovf_pulse);

  assert_wrap_unsigned_R7: assert property (@(posedge clk) disable iff (rst)
    (en && !clr && !sgn_mode) |=> ovf_pulse == (acc_out < $past(acc_out)));

  assert_wrap_signed_R8: assert property (@(posedge clk) disable iff (rst)
    (en && !clr && sgn_mode) |=>
      ovf_pulse == (($past(acc_out[TOP]) == $past(prod_ext[TOP])) &&
                    (acc_out[TOP] != $past(acc_out[TOP]))));

endmodule

bind mac_ovf_acc mac_ovf_acc_chk #(.ACC_W(ACC_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .en        (en),
  .clr       (clr),
  .sgn_mode  (sgn_mode),
  .acc_out   (acc_out),
  .ovf_pulse (ovf_pulse),
  .prod_ext  (prod_ext)
);

// File: tb/mac_ovf_acc_bench.sv
module mac_ovf_acc_bench;

  localparam int OP_W = 9;
  localparam int A_W = 6;
  localparam int B_W = 9;
  localparam int GUARD_W = 2;
  localparam int ACC_W = 2 * OP_W + GUARD_W;
  localparam longint MOD = longint'(1) << ACC_W;
  localparam longint HALF = longint'(1) << (ACC_W - 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0;
  logic clr = 1'b0;
  logic sgn_mode = 1'b0;
  logic [A_W-1:0] a_in = '0;
  logic [B_W-1:0] b_in = '0;
  logic [ACC_W-1:0] acc_out;
  logic ovf_pulse;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [ACC_W-1:0] exp_acc;
  bit exp_ovf;
  bit prev_ovf;
  longint true_sum;
  longint pulses;
  longint dirsum;

  always #10 clk = ~clk;  // 20 ns period, 50 MHz

  mac_ovf_acc #(.OP_W(OP_W), .A_W(A_W), .B_W(B_W), .GUARD_W(GUARD_W))
  u_mac_ovf_acc (
    .clk(clk), .rst(rst), .en(en), .clr(clr), .sgn_mode(sgn_mode),
    .a_in(a_in), .b_in(b_in), .acc_out(acc_out), .ovf_pulse(ovf_pulse)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // Operand value as the requirements define it (R2 zero fill, R3 sign).
  function automatic longint opv(input longint raw, input int w, input bit s);
    if (s && raw[w-1]) return raw - (longint'(1) << w);
    return raw;
  endfunction

  function automatic longint field_val(input logic [ACC_W-1:0] f, input bit s);
    if (s) return longint'($signed(f));
    return longint'(f);
  endfunction

  function automatic bit wraps(input longint old_f, input longint p, input bit s);
    if (s) return ((old_f + p) >= HALF) || ((old_f + p) < -HALF);
    return (old_f + p) >= MOD;
  endfunction

  task automatic reset_model();
    exp_acc = '0; exp_ovf = 0; prev_ovf = 0;
    true_sum = 0; pulses = 0; dirsum = 0;
  endtask

  task automatic step(input bit e, input bit c,
                      input logic [A_W-1:0] a, input logic [B_W-1:0] b);
    longint p;
    string ta;
    string tv;
    en = e; clr = c; a_in = a; b_in = b;
    p = opv(longint'(a), A_W, sgn_mode) * opv(longint'(b), B_W, sgn_mode);
    prev_ovf = exp_ovf;
    if (c) begin
      reset_model();
      ta = "R6"; tv = "R6";
    end else if (e) begin
      exp_ovf = wraps(field_val(exp_acc, sgn_mode), p, sgn_mode);
      true_sum += p;
      exp_acc = true_sum[ACC_W-1:0];
      ta = "R4";
      tv = sgn_mode ? "R8" : "R7";
      if (prev_ovf && !exp_ovf) tv = "R9";
    end else begin
      exp_ovf = 0;
      ta = "R5"; tv = prev_ovf ? "R9" : "R5";
    end
    @(posedge clk);
    @(negedge clk);
    chk(acc_out == exp_acc, ta, "acc_out", longint'(acc_out), longint'(exp_acc));
    chk(ovf_pulse == exp_ovf, tv, "ovf_pulse", longint'(ovf_pulse), longint'(exp_ovf));
    if (ovf_pulse) begin
      pulses++;
      dirsum += acc_out[ACC_W-1] ? 1 : -1;
    end
  endtask

  task automatic check_rebuild();
    longint rec;
    if (sgn_mode) rec = dirsum * MOD + longint'($signed(acc_out));
    else          rec = pulses * MOD + longint'(acc_out);
    chk(rec == true_sum, "R11", sgn_mode ? "signed rebuild" : "unsigned rebuild",
        rec, true_sum);
  endtask

  function automatic logic [A_W-1:0] rand_a(input int kind, input bit s);
    logic [A_W-1:0] v;
    v = A_W'($urandom);
    if (kind != 0) v[A_W-2] = 1'b1;
    if (s && kind != 0) v = v ^ {1'b0, {(A_W-1){v[A_W-1]}}} ^ {1'b0, {(A_W-1){1'b1}}};
    return v;
  endfunction

  function automatic logic [B_W-1:0] rand_b(input int kind, input bit s,
                                          input logic asgn);
    logic [B_W-1:0] v;
    v = B_W'($urandom);
    if (kind != 0) v[B_W-2] = 1'b1;
    if (s && kind == 1) v[B_W-1] = asgn;
    if (s && kind == 2) v[B_W-1] = ~asgn;
    return v;
  endfunction

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    reset_model();
    repeat (3) @(negedge clk);
    // R10: state after reset
    chk(acc_out == '0, "R10", "acc_out after reset", longint'(acc_out), 0);
    chk(ovf_pulse == 1'b0, "R10", "ovf after reset", longint'(ovf_pulse), 0);
    rst = 1'b0;
    // R1: accumulator width
    chk($bits(acc_out) == 2 * OP_W + GUARD_W, "R1", "acc width",
        $bits(acc_out), 2 * OP_W + GUARD_W);

    // R2: unsigned zero fill
    sgn_mode = 1'b0;
    step(1'b0, 1'b1, '0, '0);
    step(1'b1, 1'b0, 6'h3F, 9'h1FF);
    chk(acc_out == 20'd32193, "R2", "unsigned max product", longint'(acc_out), 32193);

    // R3: signed extension
    sgn_mode = 1'b1;
    step(1'b0, 1'b1, '0, '0);
    step(1'b1, 1'b0, 6'h3F, 9'h1FF);
    chk(acc_out == 20'd1, "R3", "signed -1*-1", longint'(acc_out), 1);
    step(1'b1, 1'b0, 6'h20, 9'h0FF);
    chk($signed(acc_out) == -20'sd8159, "R3", "signed -32*255 plus 1",
        longint'($signed(acc_out)), -8159);

    // Unsigned directed: wrap, hold, then clear colliding with a wrap (R6).
    sgn_mode = 1'b0;
    step(1'b0, 1'b1, '0, '0);
    while (longint'(exp_acc) + 32193 < MOD) step(1'b1, 1'b0, 6'h3F, 9'h1FF);
    step(1'b1, 1'b0, 6'h3F, 9'h1FF);
    chk(ovf_pulse == 1'b1, "R7", "directed carry wrap", longint'(ovf_pulse), 1);
    step(1'b0, 1'b0, 6'h3F, 9'h1FF);
    chk(ovf_pulse == 1'b0, "R9", "pulse drops on hold", longint'(ovf_pulse), 0);
    check_rebuild();
    while (longint'(exp_acc) + 32193 < MOD) step(1'b1, 1'b0, 6'h3F, 9'h1FF);
    step(1'b1, 1'b1, 6'h3F, 9'h1FF);
    chk(acc_out == '0 && !ovf_pulse, "R6", "clear beats wrapping add",
        longint'(acc_out), 0);

    // Signed directed: downward wrap with negative products.
    sgn_mode = 1'b1;
    step(1'b0, 1'b1, '0, '0);
    while (longint'($signed(exp_acc)) - 7936 >= -HALF) step(1'b1, 1'b0, 6'h1F, 9'h100);
    step(1'b1, 1'b0, 6'h1F, 9'h100);
    chk(ovf_pulse == 1'b1 && acc_out[ACC_W-1] == 1'b0, "R8", "downward wrap",
        longint'(ovf_pulse), 1);
    check_rebuild();

    // Random segments in both modes, three product mixes each.
    for (int m = 0; m < 2; m++) begin
      for (int kind = 0; kind < 3; kind++) begin
        sgn_mode = m[0];
        step(1'b0, 1'b1, '0, '0);
        for (int i = 0; i < 1500; i++) begin
          logic [A_W-1:0] ra;
          logic [B_W-1:0] rb;
          ra = rand_a(kind, m[0]);
          rb = rand_b(kind, m[0], ra[A_W-1]);
          step(($urandom % 5) != 0, 1'b0, ra, rb);
        end
        check_rebuild();
      end
    end

    // R10: reset in mid-run overrides an enabled add.
    en = 1'b1; rst = 1'b1;
    @(posedge clk); @(negedge clk);
    chk(acc_out == '0 && !ovf_pulse, "R10", "mid-run reset", longint'(acc_out), 0);
    rst = 1'b0; en = 1'b0;

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule